// File: doc/BRIEF.md
# Multiplexed Eight-Digit Seven-Segment Driver

This block lights a row of seven-segment digits by scanning them one at a time, fast enough that they all look lit at once. A packed data word supplies one 4-bit value per digit. At any moment exactly one digit enable is high, and the segment bus carries the hexadecimal pattern for that digit's value. A built-in prescaler divides the fast input clock, so each digit stays lit for a fixed number of clock cycles, set by a parameter.

One binary scan index drives everything that depends on the digit position: the enable decode, the data select, the upper-digit blanking compare and the decimal-point compare. Only one comparator of each kind exists, instead of one per digit.

The control inputs do three things:
- Blanking turns off the segments of every digit from a chosen index upward. Digit 0 is always kept lit.
- A single decimal point can be placed at a chosen digit.
- A test input lights every segment and the decimal point on all digits.

Top module: `segscan_driver`

## Requirements
- R1: While `rst` is high, `dig_en_o`, `seg_o` and `dp_o` are all zero. On the first clock edge after `rst` falls, digit 0 becomes the active digit (`dig_en_o` = 8'b0000_0001).
- R2: After that first edge, exactly one bit of `dig_en_o` is high at all times. Bit i selects digit i.
- R3: Digits are scanned in the order 0, 1, …, 7, 0, … and each digit stays active for exactly HOLD_CYCLES clock cycles.
- R4: Digit i shows the value `data_i[4i+3:4i]`. Segment bits are active high, with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f and 6 = g. The hex patterns are:
  - 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07
  - 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71
- R5: When `blank_en` is high, every digit whose index is at or above `blank_from` shows `seg_o` = 0. That digit's enable still scans normally.
- R6: Digit 0 is never blanked, even when `blank_from` is 0.
- R7: When `blank_en` is low, `blank_from` has no effect on the display.
- R8: `dp_o` is high only while the active digit equals `dp_at` and `dp_en` is high. Otherwise it is low.
- R9: While `test` is high, `seg_o` is 7'h7F and `dp_o` is 1 for every digit. Test mode overrides blanking and the decimal-point setting.
- R10: The outputs are registered and the inputs are sampled on every clock. A change on `data_i` while a digit is active therefore appears on `seg_o` one clock later, with the same digit still enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Asynchronous reset, active high |
| test | input | 1 | Light every segment and the decimal point |
| blank_en | input | 1 | Enable upper-digit blanking |
| blank_from | input | 3 | Lowest digit index that is blanked |
| dp_en | input | 1 | Enable the decimal point |
| dp_at | input | 3 | Digit index that carries the decimal point |
| data_i | input | 32 | Eight 4-bit digit values; digit i in bits 4i+3:4i |
| seg_o | output | 7 | Segment lines a..g in bits 0..6, active high |
| dp_o | output | 1 | Decimal-point line, active high |
| dig_en_o | output | 8 | Digit enables, one-hot, active high |

## Verification
The scan index and the prescaler are the only state in the block, and both show up directly on `dig_en_o`:
- A prescaler that counts wrong shows up within one digit slot, as a run length other than HOLD_CYCLES.
- A corrupted index shows up as an enable that skips a digit, repeats a digit or is not one-hot.

The index also steers the data select and both comparisons. If the index feeding those paths got out of step with the enables, the wrong nibble, the wrong blank decision or a misplaced decimal point would appear on `seg_o` or `dp_o` within one scan of all eight digits.

// File: rtl/segscan_pkg.sv
package segscan_pkg;
   localparam int SEG_W = 7;
   typedef logic [SEG_W-1:0] seg_t;
   localparam seg_t SEG_DARK = '0;
   localparam seg_t SEG_FULL = '1;
endpackage

// File: rtl/segscan_timer.sv
module segscan_timer #(
   parameter int DIGITS      = 8,
   parameter int HOLD_CYCLES = 1000,
   parameter int IDX_W       = $clog2(DIGITS)
) (
   input  logic             clk,
   input  logic             rst,
   output logic [IDX_W-1:0] idx_o,
   output logic             adv_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);
   localparam bit               POW2 = (DIGITS == (1 << IDX_W));

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("segscan_timer: HOLD_CYCLES must be at least 1");
   end
   if (DIGITS < 2) begin : g_bad_digits
      $error("segscan_timer: DIGITS must be at least 2");
   end

   // Prescaler: either none (one digit per clock) or a modulo counter.
   if (HOLD_CYCLES == 1) begin : g_nodiv
      assign adv_o = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(HOLD_CYCLES);
      localparam logic [PW-1:0] PMAX = PW'(HOLD_CYCLES - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or posedge rst) begin
         if (rst)                pre_q <= '0;
         else if (pre_q == PMAX) pre_q <= '0;
         else                    pre_q <= pre_q + 1'b1;
      end
      assign adv_o = (pre_q == PMAX);

      // R3: prescaler never leaves its range
      a_r3_pre_in_range: assert property (@(posedge clk) disable iff (rst)
         pre_q <= PMAX);
   end

   // Scan index: free wrap for power-of-two digit counts, compare otherwise.
   logic [IDX_W-1:0] idx_nxt;
   if (POW2) begin : g_wrap_free
      assign idx_nxt = idx_o + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_nxt = (idx_o == LAST) ? '0 : idx_o + 1'b1;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)        idx_o <= '0;
      else if (adv_o) idx_o <= idx_nxt;
   end

   // R3: index steps by one with wrap on each advance, holds otherwise
   a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
      adv_o |=> idx_o == (($past(idx_o) == LAST) ? '0 : $past(idx_o) + 1'b1));
   a_r3_index_hold: assert property (@(posedge clk) disable iff (rst)
      !adv_o |=> $stable(idx_o));
endmodule

// File: rtl/segscan_hexdec.sv
module segscan_hexdec
   import segscan_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic [NIB_W-1:0] val_i,
   output seg_t             seg_o
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("segscan_hexdec: only 4-bit values are decoded");
   end

   // Bit order g f e d c b a, bit 0 = a.
   always_comb begin
      unique case (val_i)
         4'h0: seg_o = 7'h3F;
         4'h1: seg_o = 7'h06;
         4'h2: seg_o = 7'h5B;
         4'h3: seg_o = 7'h4F;
         4'h4: seg_o = 7'h66;
         4'h5: seg_o = 7'h6D;
         4'h6: seg_o = 7'h7D;
         4'h7: seg_o = 7'h07;
         4'h8: seg_o = 7'h7F;
         4'h9: seg_o = 7'h6F;
         4'hA: seg_o = 7'h77;
         4'hB: seg_o = 7'h7C;
         4'hC: seg_o = 7'h39;
         4'hD: seg_o = 7'h5E;
         4'hE: seg_o = 7'h79;
         default: seg_o = 7'h71;
      endcase
   end
endmodule

// File: rtl/segscan_pick.sv
module segscan_pick
   import segscan_pkg::*;
#(
   parameter int DIGITS = 8,
   parameter int NIB_W  = 4,
   parameter int IDX_W  = $clog2(DIGITS)
) (
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [DIGITS*NIB_W-1:0] data_i,
   input  logic                    test_i,
   input  logic                    blank_en_i,
   input  logic [IDX_W-1:0]        blank_from_i,
   input  logic                    dp_en_i,
   input  logic [IDX_W-1:0]        dp_at_i,
   output seg_t                    seg_o,
   output logic                    dp_o,
   output logic [DIGITS-1:0]       en_o
);
   logic [NIB_W-1:0] nib;
   seg_t             pat;
   logic             blank_hit;
   logic             dp_hit;

   // One index serves select, enable decode and both compares.
   assign nib = data_i[idx_i*NIB_W +: NIB_W];

   segscan_hexdec #(.NIB_W(NIB_W)) u_dec (.val_i(nib), .seg_o(pat));

   assign en_o      = {{(DIGITS-1){1'b0}}, 1'b1} << idx_i;
   assign blank_hit = blank_en_i && (idx_i >= blank_from_i) && (idx_i != '0);
   assign dp_hit    = dp_en_i && (idx_i == dp_at_i);

   always_comb begin
      if (test_i) begin
         seg_o = SEG_FULL;
         dp_o  = 1'b1;
      end else begin
         seg_o = blank_hit ? SEG_DARK : pat;
         dp_o  = dp_hit;
      end
   end
endmodule

// File: rtl/segscan_driver.sv
module segscan_driver
   import segscan_pkg::*;
#(
   parameter int  DIGITS      = 8,
   parameter int  NIB_W       = 4,
   parameter int  HOLD_CYCLES = 1000,
   localparam int IDX_W       = $clog2(DIGITS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    test,
   input  logic                    blank_en,
   input  logic [IDX_W-1:0]        blank_from,
   input  logic                    dp_en,
   input  logic [IDX_W-1:0]        dp_at,
   input  logic [DIGITS*NIB_W-1:0] data_i,
   output logic [SEG_W-1:0]        seg_o,
   output logic                    dp_o,
   output logic [DIGITS-1:0]       dig_en_o
);
   logic [IDX_W-1:0]  scan_idx;
   logic              scan_adv;
   seg_t              seg_nxt;
   logic              dp_nxt;
   logic [DIGITS-1:0] en_nxt;

   segscan_timer #(
      .DIGITS(DIGITS), .HOLD_CYCLES(HOLD_CYCLES), .IDX_W(IDX_W)
   ) u_timer (
      .clk(clk), .rst(rst), .idx_o(scan_idx), .adv_o(scan_adv)
   );

   segscan_pick #(
      .DIGITS(DIGITS), .NIB_W(NIB_W), .IDX_W(IDX_W)
   ) u_pick (
      .idx_i(scan_idx), .data_i(data_i), .test_i(test),
      .blank_en_i(blank_en), .blank_from_i(blank_from),
      .dp_en_i(dp_en), .dp_at_i(dp_at),
      .seg_o(seg_nxt), .dp_o(dp_nxt), .en_o(en_nxt)
   );

   // Enables and segments leave through one register stage together.
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         seg_o    <= SEG_DARK;
         dp_o     <= 1'b0;
         dig_en_o <= '0;
      end else begin
         seg_o    <= seg_nxt;
         dp_o     <= dp_nxt;
         dig_en_o <= en_nxt;
      end
   end

   // R2: exactly one digit enabled once running
   a_r2_one_digit: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $countones(dig_en_o) == 1);
   // R9: test lights everything
   a_r9_test_all_on: assert property (@(posedge clk) disable iff (rst)
      test |=> (&seg_o) && dp_o);
   // R5: blanked digits are dark
   a_r5_blank_dark: assert property (@(posedge clk) disable iff (rst)
      (!test && blank_en && scan_idx >= blank_from && scan_idx != '0) |=> seg_o == '0);
   // R6: digit 0 always shows a lit pattern
   a_r6_digit0_lit: assert property (@(posedge clk) disable iff (rst)
      (!test && scan_idx == '0) |=> seg_o != '0);
   // R8: decimal point only where requested
   a_r8_dp_off: assert property (@(posedge clk) disable iff (rst)
      (!test && !(dp_en && scan_idx == dp_at)) |=> !dp_o);
   a_r8_dp_on: assert property (@(posedge clk) disable iff (rst)
      (dp_en && scan_idx == dp_at) |=> dp_o);
endmodule

// File: tb/segscan_driver_test.sv
module segscan_driver_test;
   localparam int HOLD = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        test = 1'b0, blank_en = 1'b0, dp_en = 1'b0;
   logic [2:0]  blank_from = '0, dp_at = '0;
   logic [31:0] data_i = 32'h7654_3210;
   logic [6:0]  seg_o;
   logic        dp_o;
   logic [7:0]  dig_en_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   segscan_driver #(.HOLD_CYCLES(HOLD)) uut (
      .clk(clk), .rst(rst), .test(test), .blank_en(blank_en),
      .blank_from(blank_from), .dp_en(dp_en), .dp_at(dp_at),
      .data_i(data_i), .seg_o(seg_o), .dp_o(dp_o), .dig_en_o(dig_en_o)
   );

   typedef struct packed {
      logic [31:0] data;
      logic        tst;
      logic        ben;
      logic [2:0]  bidx;
      logic        den;
      logic [2:0]  didx;
      logic [2:0]  dig;
      logic [6:0]  eseg;
      logic        edp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{32'h7654_3210, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd3, 7'h4F, 1'b0}, // R4
      '{32'h7654_3210, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 7'h3F, 1'b0}, // R4
      '{32'hFEDC_BA98, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd7, 7'h71, 1'b0}, // R4
      '{32'hFEDC_BA98, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd2, 7'h77, 1'b0}, // R4
      '{32'h7654_3210, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 3'd5, 7'h00, 1'b0}, // R5 above
      '{32'h7654_3210, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 3'd4, 7'h00, 1'b0}, // R5 at
      '{32'h7654_3210, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 3'd3, 7'h4F, 1'b0}, // R5 below
      '{32'h7654_3210, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0, 7'h3F, 1'b0}, // R6
      '{32'h7654_3210, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd1, 7'h00, 1'b0}, // R5 from 0
      '{32'h7654_3210, 1'b0, 1'b0, 3'd0, 1'b1, 3'd6, 3'd6, 7'h7D, 1'b1}, // R8 on
      '{32'h7654_3210, 1'b0, 1'b0, 3'd0, 1'b1, 3'd6, 3'd5, 7'h6D, 1'b0}, // R8 other
      '{32'h7654_3210, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 3'd3, 7'h7F, 1'b1}, // R9
      '{32'h7654_3210, 1'b0, 1'b0, 3'd1, 1'b0, 3'd0, 3'd5, 7'h6D, 1'b0}, // R7
      '{32'h7654_3210, 1'b0, 1'b0, 3'd0, 1'b0, 3'd2, 3'd2, 7'h5B, 1'b0}  // R8 off
   };

   function automatic logic [6:0] hexpat(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[v];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Sample point ends just after the edge that brought digit k in.
   task automatic enter_digit(input int k);
      @(negedge clk);
      while (dig_en_o == (8'd1 << k)) @(negedge clk);
      while (dig_en_o != (8'd1 << k)) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] prev;
      int run;

      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1 seg in reset", 32'(seg_o), 32'h0);
      check("R1 dp in reset", 32'(dp_o), 32'h0);
      check("R1 enables in reset", 32'(dig_en_o), 32'h0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 first digit", 32'(dig_en_o), 32'h01);

      // R2/R3: one-hot, order and hold length
      prev = dig_en_o;
      run  = 1;
      for (int c = 0; c < 2 * 8 * HOLD; c++) begin
         @(negedge clk);
         check("R2 one-hot", 32'($countones(dig_en_o)), 32'd1);
         if (dig_en_o == prev) begin
            run++;
         end else begin
            check("R3 hold length", 32'(run), 32'(HOLD));
            check("R3 next digit", 32'(dig_en_o), 32'({prev[6:0], prev[7]}));
            prev = dig_en_o;
            run  = 1;
         end
      end

      // R4: all sixteen patterns across two words
      for (int w = 0; w < 2; w++) begin
         data_i = (w == 0) ? 32'h7654_3210 : 32'hFEDC_BA98;
         for (int k = 0; k < 8; k++) begin
            enter_digit(k);
            check("R4 pattern", 32'(seg_o), 32'(hexpat(data_i[4*k +: 4])));
         end
      end

      // Vector table
      for (int i = 0; i < NV; i++) begin
         data_i     = VECS[i].data;
         test       = VECS[i].tst;
         blank_en   = VECS[i].ben;
         blank_from = VECS[i].bidx;
         dp_en      = VECS[i].den;
         dp_at      = VECS[i].didx;
         enter_digit(int'(VECS[i].dig));
         check($sformatf("vector %0d seg", i), 32'(seg_o), 32'(VECS[i].eseg));
         check($sformatf("vector %0d dp", i), 32'(dp_o), 32'(VECS[i].edp));
      end
      test = 1'b0; blank_en = 1'b0; dp_en = 1'b0;

      // R10: change data mid-slot, visible one clock later on same digit
      data_i = 32'h7654_3210;
      enter_digit(2);
      data_i = 32'h0000_0A00;
      @(negedge clk);
      check("R10 same digit", 32'(dig_en_o), 32'h04);
      check("R10 new value", 32'(seg_o), 32'h77);

      // R1: reset mid-scan
      enter_digit(5);
      rst = 1'b1;
      #1;
      check("R1 async clear enables", 32'(dig_en_o), 32'h0);
      check("R1 async clear seg", 32'(seg_o), 32'h0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 restart at digit 0", 32'(dig_en_o), 32'h01);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule